// File: doc/BRIEF.md
# Slow-Domain Register Write Tracker

This block sits on the bus side of a chip and tracks register writes that travel into a slow, always-on domain. The slow domain is modelled as a fixed number of clock cycles. A write to a slow-path register is accepted, held for that many cycles, and only then lands in the register. While it is in flight, the block reports its progress through four status flags: busy, ready-for-next, complete and error.

The interrupt-enable register is the one register that skips the slow path. It updates on the same clock edge as the bus write and never raises the complete flag. A read of the status register clears the complete flag. The error flag is cleared by writing a 1 to its bit, and that clearing write itself goes through the slow path. A test input can force the write that is completing to fail, so that the error path can be exercised.

Top module: `slowwr_tracker`

## Requirements
- R1: After reset, busy, complete and error are 0, ready-for-next is 1, the interrupt-enable bits are 0, the interrupt is 0 and every data register reads 0.
- R2: A slow-path write (data register addresses 0 to NUM_REGS-1, or the status address NUM_REGS) accepted on clock edge t raises busy after edge t. The target is updated, busy clears and complete sets on edge t+LATENCY, and not earlier.
- R3: Ready-for-next is the inverse of busy. A slow-path write is accepted only while ready-for-next is 1.
- R4: A slow-path write presented while busy is 1, including in the cycle in which the pending write completes, is dropped and sets the error flag. The pending write still completes on schedule.
- R5: A write to the interrupt-enable address (NUM_REGS+1) takes effect on that clock edge, reads back at once, does not start the slow path and does not set complete.
- R6: A read of the status address clears complete. Reads of any other address leave it unchanged.
- R7: When a slow-path completion and a status read fall on the same edge, complete ends up 1.
- R8: A completed slow-path write to the status address with bit 7 = 1 clears error on its completion edge. Error stays set while that write is in flight, and a status write with bit 7 = 0 leaves error set. Either write sets complete on completion.
- R9: The status word reads busy at bit 10, ready-for-next at bit 9, complete at bit 8 and error at bit 7. All other bits read 0.
- R10: The interrupt-enable bits sit at bit 9 (ready-for-next), bit 8 (complete) and bit 7 (error). The interrupt output is the OR of each flag ANDed with its enable, and it follows flag or enable changes with no added register.
- R11: When err_inject is 1 on the completion edge, the pending write is discarded: the target keeps its old value, error sets, complete stays as it was, and busy clears as usual.
- R12: Addresses above NUM_REGS+1 read 0, and a write to them is ignored: it does not start the slow path and does not set error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for the status read side effect |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| err_inject | input | 1 | Test input that fails the write completing on this edge |
| stat_busy | output | 1 | A slow-path write is in flight |
| stat_next | output | 1 | A new slow-path write can be accepted |
| stat_done | output | 1 | Write-complete flag |
| stat_err | output | 1 | Write-error flag |
| irq | output | 1 | Interrupt, the OR of the enabled flags |

## Verification
The slow path is exercised with four input patterns: a lone data write, which pins down the exact completion cycle; a second write issued while busy, which separates a dropped collision from a queued one; a status read issued on the completion edge, which shows which of set and clear wins; and completions carrying an injected fault, which separate a committed write from a discarded one. Error clearing is tried both with bit 7 set and with it clear, so a design that clears on any status write is caught. The interrupt-enable write is checked against the unchanged busy and complete flags and against the interrupt line in the same cycle, which separates bus-speed updates from slow-path ones.

// File: rtl/swt_pkg.sv
// Shared definitions for the slow-domain write tracker.
// Bit positions are fixed because software decodes them from the status
// and interrupt-enable words.
package swt_pkg;

    localparam int WBUSY_POS = 10;
    localparam int WNEXT_POS = 9;
    localparam int WDONE_POS = 8;
    localparam int WERR_POS  = 7;

    // Address class of a bus access
    typedef enum logic [1:0] {
        AC_NONE = 2'd0,
        AC_DATA = 2'd1,
        AC_STAT = 2'd2,
        AC_IEN  = 2'd3
    } addr_cls_t;

    // Interrupt enables, one per flag that can interrupt
    typedef struct packed {
        logic next;
        logic done;
        logic err;
    } ien_t;

endpackage

// File: rtl/swt_addr_dec.sv
// Address decoder.
// Sorts a word address into data register, status, interrupt enable or
// unmapped. Assumes NUM_REGS+1 fits in ADDR_W bits and IDX_W <= ADDR_W.
module swt_addr_dec
    import swt_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_t         cls,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] IEN_ADDR  = ADDR_W'(NUM_REGS + 1);

    // Classify the address and extract the data register index
    always_comb begin
        idx = addr[IDX_W-1:0];
        if (addr < STAT_ADDR) begin
            cls = AC_DATA;
        end else if (addr == STAT_ADDR) begin
            cls = AC_STAT;
        end else if (addr == IEN_ADDR) begin
            cls = AC_IEN;
        end else begin
            cls = AC_NONE;
        end
    end

endmodule

// File: rtl/swt_slow_path.sv
// Slow-domain latency model.
// Holds one accepted write for LATENCY cycles and flags its completion.
// Assumes the caller raises start only while busy is 0, and LATENCY >= 1.
module swt_slow_path #(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 2,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_is_stat,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic              finish,
    output logic              pend_is_stat,
    output logic [IDX_W-1:0]  pend_idx,
    output logic [DATA_W-1:0] pend_data
);

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining slow-domain cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_LAST;
        end
    end

    // Capture the accepted write for delivery at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_is_stat <= 1'b0;
            pend_idx     <= '0;
            pend_data    <= '0;
        end else if (start) begin
            pend_is_stat <= start_is_stat;
            pend_idx     <= start_idx;
            pend_data    <= start_data;
        end
    end

    // Busy while cycles remain; finish on the last one
    always_comb begin
        busy   = (cnt_q != '0);
        finish = (cnt_q == CNT_LAST);
    end

endmodule

// File: rtl/swt_flags.sv
// Status flags and interrupt enables.
// Keeps the complete and error flags, the bus-speed enable register and the
// interrupt OR. Set events take priority over clears on the same edge.
module swt_flags
    import swt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic       fail,
    input  logic       collide,
    input  logic       clr_err,
    input  logic       stat_read,
    input  logic       ien_wr,
    input  ien_t       ien_wdata,
    input  logic       wnext,
    output logic       done,
    output logic       err,
    output ien_t       ien,
    output logic       irq
);

    // Complete flag: set by a committed write, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (commit) begin
            done <= 1'b1;
        end else if (stat_read) begin
            done <= 1'b0;
        end
    end

    // Error flag: set by a collision or a failed commit, cleared by a committed clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (collide || fail) begin
            err <= 1'b1;
        end else if (clr_err) begin
            err <= 1'b0;
        end
    end

    // Interrupt enables update at bus speed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (ien_wr) begin
            ien <= ien_wdata;
        end
    end

    // Interrupt is the OR of enabled flags, no register
    always_comb begin
        irq = (ien.next & wnext) | (ien.done & done) | (ien.err & err);
    end

endmodule

// File: rtl/swt_regfile.sv
// Slow-path data registers.
// Each register is written only when a pending data write commits.
// The read port is combinational.
module swt_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        // Store committed data for this register index
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                regs_q[gi] <= wr_data;
            end
        end
    end

    // Select the addressed register for the read port
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/slowwr_tracker.sv
// Slow-domain register write tracker, top level.
// Accepts bus writes, sends all but the interrupt-enable write through a
// LATENCY-cycle slow path, and reports progress through status flags and
// one interrupt. Assumes a write strobe lasts a single cycle per write and
// DATA_W >= 11 so that every status bit fits.
module slowwr_tracker
    import swt_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    parameter int LATENCY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              err_inject,
    output logic              stat_busy,
    output logic              stat_next,
    output logic              stat_done,
    output logic              stat_err,
    output logic              irq
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    addr_cls_t         cls;
    logic [IDX_W-1:0]  idx;
    logic              slow_req;
    logic              accept;
    logic              collide;
    logic              finish;
    logic              commit;
    logic              fail;
    logic              pend_is_stat;
    logic [IDX_W-1:0]  pend_idx;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] ien_word;
    ien_t              ien;
    ien_t              ien_wdata;
    logic              busy;
    logic              done;
    logic              err;

    swt_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr (bus_addr),
        .cls  (cls),
        .idx  (idx)
    );

    // Route the write: accept when idle, flag a collision when busy
    always_comb begin
        slow_req = bus_wr && ((cls == AC_DATA) || (cls == AC_STAT));
        accept   = slow_req && !busy;
        collide  = slow_req && busy;
        commit   = finish && !err_inject;
        fail     = finish && err_inject;
    end

    swt_slow_path #(
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .LATENCY (LATENCY)
    ) u_slow (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept),
        .start_is_stat (cls == AC_STAT),
        .start_idx     (idx),
        .start_data    (bus_wdata),
        .busy          (busy),
        .finish        (finish),
        .pend_is_stat  (pend_is_stat),
        .pend_idx      (pend_idx),
        .pend_data     (pend_data)
    );

    // Pick the enable bits out of the write data at their flag positions
    always_comb begin
        ien_wdata.next = bus_wdata[WNEXT_POS];
        ien_wdata.done = bus_wdata[WDONE_POS];
        ien_wdata.err  = bus_wdata[WERR_POS];
    end

    swt_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .fail      (fail),
        .collide   (collide),
        .clr_err   (commit && pend_is_stat && pend_data[WERR_POS]),
        .stat_read (bus_rd && (cls == AC_STAT)),
        .ien_wr    (bus_wr && (cls == AC_IEN)),
        .ien_wdata (ien_wdata),
        .wnext     (!busy),
        .done      (done),
        .err       (err),
        .ien       (ien),
        .irq       (irq)
    );

    swt_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit && !pend_is_stat),
        .wr_idx  (pend_idx),
        .wr_data (pend_data),
        .rd_idx  (idx),
        .rd_data (reg_rdata)
    );

    // Assemble the status and enable words at their fixed bit positions
    always_comb begin
        stat_word            = '0;
        stat_word[WBUSY_POS] = busy;
        stat_word[WNEXT_POS] = !busy;
        stat_word[WDONE_POS] = done;
        stat_word[WERR_POS]  = err;
        ien_word             = '0;
        ien_word[WNEXT_POS]  = ien.next;
        ien_word[WDONE_POS]  = ien.done;
        ien_word[WERR_POS]   = ien.err;
    end

    // Read data multiplexer
    always_comb begin
        unique case (cls)
            AC_DATA: bus_rdata = reg_rdata;
            AC_STAT: bus_rdata = stat_word;
            AC_IEN:  bus_rdata = ien_word;
            default: bus_rdata = '0;
        endcase
    end

    // Drive the flag outputs
    always_comb begin
        stat_busy = busy;
        stat_next = !busy;
        stat_done = done;
        stat_err  = err;
    end

endmodule

// File: rtl/swt_checker.sv
// Protocol checker for the slow-domain write tracker, bound to the top.
// Observes ports only; a local counter measures the busy window.
module swt_checker #(
    parameter int ADDR_W   = 3,
    parameter int NUM_REGS = 4,
    parameter int LATENCY  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              stat_busy,
    input logic              stat_next,
    input logic              stat_done,
    input logic              stat_err,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] IEN_ADDR  = ADDR_W'(NUM_REGS + 1);

    logic        slow_addr;
    logic        hole_addr;
    logic [15:0] win_cnt;

    // Classify the address independently of the design's decoder
    always_comb begin
        slow_addr = (bus_addr <= STAT_ADDR);
        hole_addr = (bus_addr > IEN_ADDR);
    end

    // Count the cycles busy has been high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (stat_busy) begin
            if (win_cnt != 16'hFFFF) begin
                win_cnt <= win_cnt + 16'd1;
            end
        end else begin
            win_cnt <= '0;
        end
    end

    // R2
    lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_busy) |-> (win_cnt == 16'(LATENCY)));

    // R2
    done_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done) |-> $fell(stat_busy));

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && slow_addr && stat_next) |=> stat_busy);

    // R4
    collide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && slow_addr && stat_busy) |=> stat_err);

    // R5
    ien_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == IEN_ADDR) && !stat_busy) |=> !stat_busy);

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == STAT_ADDR)) |=> (!stat_done || $fell(stat_busy)));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_err) |-> $fell(stat_busy));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_next || stat_done || stat_err));

    // R12
    hole_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hole_addr && !stat_busy) |=> (!stat_busy && ($past(stat_err) == stat_err)));

endmodule

bind slowwr_tracker swt_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .LATENCY  (LATENCY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .stat_busy (stat_busy),
    .stat_next (stat_next),
    .stat_done (stat_done),
    .stat_err  (stat_err),
    .irq       (irq)
);

// File: tb/tb_slowwr_tracker.sv
// Scoreboard bench: the driver pushes expected observations after each bus
// cycle, the monitor pops and compares them on the following falling edge.
module tb_slowwr_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_inject = 1'b0;
    logic        stat_busy, stat_next, stat_done, stat_err, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam int S_BUSY = 0, S_NEXT = 1, S_DONE = 2, S_ERR = 3, S_IRQ = 4, S_RDATA = 5;
    localparam logic [2:0] A_STAT = 3'd4, A_IEN = 3'd5;

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    slowwr_tracker dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .err_inject (err_inject),
        .stat_busy  (stat_busy),
        .stat_next  (stat_next),
        .stat_done  (stat_done),
        .stat_err   (stat_err),
        .irq        (irq)
    );

    function automatic logic [31:0] observe(input int sel);
        case (sel)
            S_BUSY:  return {31'b0, stat_busy};
            S_NEXT:  return {31'b0, stat_next};
            S_DONE:  return {31'b0, stat_done};
            S_ERR:   return {31'b0, stat_err};
            S_IRQ:   return {31'b0, irq};
            default: return bus_rdata;
        endcase
    endfunction

    task automatic expect_val(input string req, input int sel, input logic [31:0] exp);
        item_t it;
        it.req = req;
        it.sel = sel;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic bus_cycle(input logic wr, input logic rd, input logic [2:0] a,
                             input logic [31:0] d, input logic inj);
        @(negedge clk);
        #1;
        bus_wr = wr;
        bus_rd = rd;
        bus_addr = a;
        bus_wdata = d;
        err_inject = inj;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        bus_cycle(1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
    endtask

    // Monitor: compare queued expectations on each falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sb_q.pop_front();
                got = observe(it.sel);
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle();
        expect_val("R1", S_BUSY, 0);
        expect_val("R1", S_NEXT, 1);
        expect_val("R1", S_DONE, 0);
        expect_val("R1", S_ERR, 0);
        expect_val("R1", S_IRQ, 0);
        bus_cycle(1'b0, 1'b1, 3'd0, 32'd0, 1'b0);
        expect_val("R1", S_RDATA, 0);

        // R2/R3 lone data write, LATENCY = 4
        bus_cycle(1'b1, 1'b0, 3'd1, 32'h1234_5678, 1'b0);
        expect_val("R2", S_BUSY, 1);
        expect_val("R3", S_NEXT, 0);
        bus_cycle(1'b0, 1'b1, 3'd1, 32'd0, 1'b0);
        expect_val("R2", S_RDATA, 0);
        expect_val("R2", S_BUSY, 1);
        idle();
        idle();
        expect_val("R2", S_BUSY, 1);
        expect_val("R2", S_DONE, 0);
        idle();
        expect_val("R2", S_BUSY, 0);
        expect_val("R3", S_NEXT, 1);
        expect_val("R2", S_DONE, 1);
        bus_cycle(1'b0, 1'b1, 3'd1, 32'd0, 1'b0);
        expect_val("R2", S_RDATA, 32'h1234_5678);
        expect_val("R6", S_DONE, 1);

        // R6/R9 status read clears complete
        bus_cycle(1'b0, 1'b1, A_STAT, 32'd0, 1'b0);
        expect_val("R6", S_DONE, 0);
        expect_val("R9", S_RDATA, 32'h0000_0200);

        // R5/R10 interrupt enables at bus speed
        bus_cycle(1'b1, 1'b0, A_IEN, 32'h0000_0380, 1'b0);
        expect_val("R5", S_BUSY, 0);
        expect_val("R5", S_DONE, 0);
        expect_val("R10", S_IRQ, 1);
        bus_cycle(1'b0, 1'b1, A_IEN, 32'd0, 1'b0);
        expect_val("R5", S_RDATA, 32'h0000_0380);
        bus_cycle(1'b1, 1'b0, A_IEN, 32'h0000_0100, 1'b0);
        expect_val("R10", S_IRQ, 0);

        // R4 collision while busy
        bus_cycle(1'b1, 1'b0, 3'd2, 32'h0000_0055, 1'b0);
        bus_cycle(1'b1, 1'b0, 3'd2, 32'h0000_0066, 1'b0);
        expect_val("R4", S_ERR, 1);
        expect_val("R4", S_BUSY, 1);
        idle();
        idle();
        expect_val("R4", S_BUSY, 1);
        idle();
        expect_val("R4", S_BUSY, 0);
        expect_val("R4", S_DONE, 1);
        expect_val("R10", S_IRQ, 1);
        bus_cycle(1'b0, 1'b1, 3'd2, 32'd0, 1'b0);
        expect_val("R4", S_RDATA, 32'h0000_0055);
        expect_val("R4", S_ERR, 1);

        // R7 status read on the completion edge
        bus_cycle(1'b0, 1'b1, A_STAT, 32'd0, 1'b0);
        expect_val("R9", S_RDATA, 32'h0000_0280);
        expect_val("R6", S_DONE, 0);
        expect_val("R10", S_IRQ, 0);
        bus_cycle(1'b1, 1'b0, 3'd3, 32'h0000_0007, 1'b0);
        idle();
        idle();
        idle();
        bus_cycle(1'b0, 1'b1, A_STAT, 32'd0, 1'b0);
        expect_val("R7", S_DONE, 1);
        expect_val("R10", S_IRQ, 1);
        expect_val("R9", S_RDATA, 32'h0000_0380);

        // R8 status write with bit 7 clear leaves error
        bus_cycle(1'b1, 1'b0, A_STAT, 32'h0000_0000, 1'b0);
        idle();
        idle();
        idle();
        idle();
        expect_val("R8", S_ERR, 1);
        expect_val("R8", S_DONE, 1);

        // R8 status write with bit 7 set clears error at completion
        bus_cycle(1'b1, 1'b0, A_STAT, 32'h0000_0080, 1'b0);
        expect_val("R8", S_ERR, 1);
        expect_val("R8", S_BUSY, 1);
        idle();
        idle();
        idle();
        expect_val("R8", S_ERR, 1);
        idle();
        expect_val("R8", S_ERR, 0);
        expect_val("R8", S_DONE, 1);
        expect_val("R8", S_BUSY, 0);

        // R11 injected fault on the completion edge
        bus_cycle(1'b0, 1'b1, A_STAT, 32'd0, 1'b0);
        expect_val("R6", S_DONE, 0);
        bus_cycle(1'b1, 1'b0, 3'd0, 32'h0000_BEEF, 1'b0);
        idle();
        idle();
        idle();
        bus_cycle(1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
        expect_val("R11", S_ERR, 1);
        expect_val("R11", S_DONE, 0);
        expect_val("R11", S_BUSY, 0);
        bus_cycle(1'b0, 1'b1, 3'd0, 32'd0, 1'b0);
        expect_val("R11", S_RDATA, 0);
        expect_val("R10", S_IRQ, 0);
        bus_cycle(1'b1, 1'b0, A_IEN, 32'h0000_0080, 1'b0);
        expect_val("R10", S_IRQ, 1);

        // R12 unmapped address
        bus_cycle(1'b1, 1'b0, 3'd6, 32'hFFFF_FFFF, 1'b0);
        expect_val("R12", S_BUSY, 0);
        expect_val("R12", S_NEXT, 1);
        bus_cycle(1'b0, 1'b1, 3'd6, 32'd0, 1'b0);
        expect_val("R12", S_RDATA, 0);

        idle();
        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule